// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block decides one floating-point comparison and turns it into condition-code updates. It accepts two 64-bit operands in one of three layouts: a single-precision value in the low 32 bits, a double-precision value, or a pair of single-precision values packed into the upper and lower halves. A 4-bit predicate chooses which relations count as "true": any OR of less-than, equal and unordered. One further predicate bit turns quiet-NaN compares into signalling ones. An optional magnitude mode drops both signs before the ordered compare.

The unit is purely combinational. Its outputs are a vector of condition-code values, a matching vector of write enables, and an invalid-operation flag for the status register. When the invalid flag is raised and the invalid trap is enabled, the trap takes precedence and no condition code is written. Paired compares update two neighbouring condition codes from a single index.

Top module: `fp_cmp_cond`

## Requirements
- R1: With `fmt` = 0 (single), only `op_a[31:0]` and `op_b[31:0]` are compared (8-bit exponent, 23-bit fraction), and bits 63:32 have no effect on any output.
- R2: With `fmt` = 1 (double), the full 64-bit operands are compared as 11-bit exponent, 52-bit fraction values.
- R3: The result is (`pred[2]` and less) or (`pred[1]` and equal) or (`pred[0]` and unordered). Less and equal are never both true.
- R4: If either operand is a NaN (exponent all ones, fraction nonzero), the relation is unordered, with less and equal both false.
- R5: `invalid` is raised when an operand is a signalling NaN (a NaN whose fraction MSB is clear), or when any operand is a NaN and `pred[3]` is set.
- R6: With `abs_en` = 1, both sign bits are cleared before the ordered comparison.
- R7: +0 and -0 compare equal. Infinities are ordered by sign. Other values are ordered as sign-magnitude numbers.
- R8: With `fmt` = 2 (paired), the low halves set code `cc_idx` and the high halves set code `cc_idx`+1. `invalid` is the OR of both halves.
- R9: Exactly the addressed codes have `cc_wen` set. A paired write whose upper index reaches `CC_COUNT` drops the upper write only. `cc_val` is zero wherever `cc_wen` is zero.
- R10: When `invalid` and `inv_trap_en` are both 1, `trap` is 1 and `cc_wen` is all zero.
- R11: `fmt` = 3 is reserved: it gives no write and no invalid flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| fmt | input | 2 | 0 single, 1 double, 2 paired single, 3 reserved |
| abs_en | input | 1 | Compare magnitudes only |
| pred | input | 4 | [3] signal on any NaN, [2] less, [1] equal, [0] unordered |
| cc_idx | input | CCW | Index of the first condition code to write |
| inv_trap_en | input | 1 | Invalid-operation trap enable |
| cc_val | output | CC_COUNT | Condition-code values, valid where enabled |
| cc_wen | output | CC_COUNT | Condition-code write enables |
| invalid | output | 1 | Invalid-operation status |
| trap | output | 1 | Invalid trap taken; writes suppressed |

## Verification
The bench builds the block with the default `CC_COUNT` of 8, so the index is 3 bits wide. With that setting, a paired compare at index 7 reaches the point where the upper write falls off the end, and index 6 fills the top two codes. Expected results come from a reference that maps each non-NaN value to a signed integer key and compares the keys. This formulation is independent of the sign-magnitude logic in the design.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [1:0] {
    FMT_SGL  = 2'd0,
    FMT_DBL  = 2'd1,
    FMT_PAIR = 2'd2,
    FMT_RSV  = 2'd3
  } cmp_fmt_e;

  localparam int PRED_SIG = 3;
  localparam int PRED_LT  = 2;
  localparam int PRED_EQ  = 1;
  localparam int PRED_UN  = 0;

  function automatic logic pred_hit(input logic [3:0] p, input logic lt,
                                    input logic eq, input logic un);
    return (p[PRED_LT] & lt) | (p[PRED_EQ] & eq) | (p[PRED_UN] & un);
  endfunction

  function automatic logic inv_hit(input logic [3:0] p, input logic sig_nan,
                                   input logic any_nan);
    return sig_nan | (p[PRED_SIG] & any_nan);
  endfunction

endpackage

// File: rtl/fpc_lane.sv
module fpc_lane #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = EXP_W + FRAC_W + 1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         mag_only,
  output logic         lt,
  output logic         eq,
  output logic         un,
  output logic         sig_nan
);

  function automatic logic is_nan(input logic [W-1:0] v);
    return (&v[W-2 -: EXP_W]) && (v[FRAC_W-1:0] != '0);
  endfunction

  function automatic logic is_snan(input logic [W-1:0] v);
    return is_nan(v) && !v[FRAC_W-1];
  endfunction

  logic           a_s, b_s;
  logic [W-2:0]   a_m, b_m;
  logic           lt_raw;

  always_comb begin
    a_s = a[W-1] & ~mag_only;
    b_s = b[W-1] & ~mag_only;
    a_m = a[W-2:0];
    b_m = b[W-2:0];
    un  = is_nan(a) | is_nan(b);
    sig_nan = is_snan(a) | is_snan(b);
    eq  = !un && ((a_m == '0 && b_m == '0) || (a_s == b_s && a_m == b_m));
    if (a_s != b_s)
      lt_raw = a_s;
    else if (!a_s)
      lt_raw = a_m < b_m;
    else
      lt_raw = a_m > b_m;
    lt = !un && !eq && lt_raw;
  end

  always_comb begin
    a_r4_unord_excl: assert (!(un && (lt || eq)));
    a_r3_lt_eq_excl: assert (!(lt && eq));
    a_r5_snan_is_nan: assert (!(sig_nan && !un));
  end

endmodule

// File: rtl/fp_cmp_cond.sv
module fp_cmp_cond
  import fpcmp_pkg::*;
#(
  parameter int CC_COUNT = 8,
  localparam int CCW = (CC_COUNT > 1) ? $clog2(CC_COUNT) : 1
) (
  input  logic [63:0]         op_a,
  input  logic [63:0]         op_b,
  input  logic [1:0]          fmt,
  input  logic                abs_en,
  input  logic [3:0]          pred,
  input  logic [CCW-1:0]      cc_idx,
  input  logic                inv_trap_en,
  output logic [CC_COUNT-1:0] cc_val,
  output logic [CC_COUNT-1:0] cc_wen,
  output logic                invalid,
  output logic                trap
);

  logic [1:0] s_lt, s_eq, s_un, s_sig;
  logic       d_lt, d_eq, d_un, d_sig;

  for (genvar g = 0; g < 2; g++) begin : g_sgl
    fpc_lane #(.EXP_W(8), .FRAC_W(23)) u_lane (
      .a(op_a[32*g +: 32]), .b(op_b[32*g +: 32]), .mag_only(abs_en),
      .lt(s_lt[g]), .eq(s_eq[g]), .un(s_un[g]), .sig_nan(s_sig[g])
    );
  end

  fpc_lane #(.EXP_W(11), .FRAC_W(52)) u_dbl (
    .a(op_a), .b(op_b), .mag_only(abs_en),
    .lt(d_lt), .eq(d_eq), .un(d_un), .sig_nan(d_sig)
  );

  logic res_lo, res_hi, inv_raw, fmt_ok, two_codes, write_ok;
  int   lo_i;

  always_comb begin
    res_lo = 1'b0; res_hi = 1'b0; inv_raw = 1'b0;
    fmt_ok = 1'b1; two_codes = 1'b0;
    unique case (cmp_fmt_e'(fmt))
      FMT_SGL: begin
        res_lo  = pred_hit(pred, s_lt[0], s_eq[0], s_un[0]);
        inv_raw = inv_hit(pred, s_sig[0], s_un[0]);
      end
      FMT_DBL: begin
        res_lo  = pred_hit(pred, d_lt, d_eq, d_un);
        inv_raw = inv_hit(pred, d_sig, d_un);
      end
      FMT_PAIR: begin
        res_lo    = pred_hit(pred, s_lt[0], s_eq[0], s_un[0]);
        res_hi    = pred_hit(pred, s_lt[1], s_eq[1], s_un[1]);
        inv_raw   = inv_hit(pred, s_sig[0], s_un[0]) | inv_hit(pred, s_sig[1], s_un[1]);
        two_codes = 1'b1;
      end
      default: fmt_ok = 1'b0;
    endcase
    invalid  = fmt_ok & inv_raw;
    trap     = invalid & inv_trap_en;
    lo_i     = int'(cc_idx);
    write_ok = fmt_ok && !trap && (lo_i < CC_COUNT);
    for (int i = 0; i < CC_COUNT; i++) begin
      cc_wen[i] = write_ok && ((i == lo_i) || (two_codes && i == lo_i + 1));
      cc_val[i] = cc_wen[i] && ((i == lo_i) ? res_lo : res_hi);
    end
  end

  always_comb begin
    a_r10_trap_no_write: assert (!(trap && (cc_wen != '0)));
    a_r9_val_masked: assert ((cc_val & ~cc_wen) == '0);
    a_r8_at_most_two: assert ($countones(cc_wen) <= 2);
    a_r11_reserved_quiet: assert (!(fmt == 2'd3 && (invalid || cc_wen != '0)));
  end

endmodule

// File: tb/fp_cmp_cond_test.sv
module fp_cmp_cond_test;

  localparam int NCC = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [63:0]    op_a, op_b;
  logic [1:0]     fmt;
  logic           abs_en, inv_trap_en;
  logic [3:0]     pred;
  logic [2:0]     cc_idx;
  logic [NCC-1:0] cc_val, cc_wen;
  logic           invalid, trap;

  fp_cmp_cond #(.CC_COUNT(NCC)) uut (
    .op_a(op_a), .op_b(op_b), .fmt(fmt), .abs_en(abs_en), .pred(pred),
    .cc_idx(cc_idx), .inv_trap_en(inv_trap_en), .cc_val(cc_val),
    .cc_wen(cc_wen), .invalid(invalid), .trap(trap)
  );

  typedef struct {
    logic [NCC-1:0] val;
    logic [NCC-1:0] wen;
    logic           inv;
    logic           trp;
    string          tag;
  } exp_t;

  exp_t q[$];
  int n_run = 0;
  int n_fail = 0;

  // returns {snan, nan, lt, eq}; one value as a signed integer key
  function automatic logic [3:0] model(input logic [63:0] a, input logic [63:0] b,
                                       input bit dbl, input bit ab);
    int ew = dbl ? 11 : 8;
    int fw = dbl ? 52 : 23;
    logic [63:0] ma, mb, fa, fb, ea, eb;
    logic sa, sb, na, nb, qa, qb;
    longint ka, kb;
    ma = dbl ? {1'b0, a[62:0]} : {33'd0, a[30:0]};
    mb = dbl ? {1'b0, b[62:0]} : {33'd0, b[30:0]};
    sa = (dbl ? a[63] : a[31]) & ~ab;
    sb = (dbl ? b[63] : b[31]) & ~ab;
    fa = ma & ((64'd1 << fw) - 1);
    fb = mb & ((64'd1 << fw) - 1);
    ea = ma >> fw;
    eb = mb >> fw;
    na = (ea == (64'd1 << ew) - 1) && fa != 0;
    nb = (eb == (64'd1 << ew) - 1) && fb != 0;
    qa = fa[fw-1];
    qb = fb[fw-1];
    ka = sa ? -longint'(ma) : longint'(ma);
    kb = sb ? -longint'(mb) : longint'(mb);
    if (na || nb) return {(na && !qa) || (nb && !qb), 1'b1, 2'b00};
    return {2'b00, ka < kb, ka == kb};
  endfunction

  task automatic go(input logic [63:0] a, input logic [63:0] b, input logic [1:0] f,
                    input logic ab, input logic [3:0] p, input int cc,
                    input logic te, input string tag);
    exp_t e;
    logic [3:0] m0, m1;
    logic r0, r1, iv, ok;
    @(posedge clk);
    #1;
    op_a = a; op_b = b; fmt = f; abs_en = ab; pred = p;
    cc_idx = 3'(cc); inv_trap_en = te;
    m0 = model(a, b, f == 2'd1, ab);
    m1 = model({32'd0, a[63:32]}, {32'd0, b[63:32]}, 1'b0, ab);
    r0 = |(p[2:0] & {m0[1], m0[0], m0[2]});
    r1 = |(p[2:0] & {m1[1], m1[0], m1[2]});
    iv = m0[3] | (p[3] & m0[2]);
    if (f == 2'd2) iv = iv | m1[3] | (p[3] & m1[2]);
    if (f == 2'd3) iv = 1'b0;
    e.inv = iv;
    e.trp = iv & te;
    ok = (f != 2'd3) && !e.trp;
    e.wen = '0; e.val = '0;
    if (ok) begin
      e.wen[cc] = 1'b1; e.val[cc] = r0;
      if (f == 2'd2 && cc + 1 < NCC) begin
        e.wen[cc+1] = 1'b1; e.val[cc+1] = r1;
      end
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (cc_val !== e.val || cc_wen !== e.wen || invalid !== e.inv || trap !== e.trp) begin
        n_fail++;
        $display("FAIL %s: got val=%b wen=%b inv=%b trap=%b exp val=%b wen=%b inv=%b trap=%b",
                 e.tag, cc_val, cc_wen, invalid, trap, e.val, e.wen, e.inv, e.trp);
      end
    end
  end

  localparam logic [31:0] S1 = 32'h3F80_0000, S2 = 32'h4000_0000, SN1 = 32'hBF80_0000;
  localparam logic [31:0] SZ = 32'h0, SNZ = 32'h8000_0000, SINF = 32'h7F80_0000;
  localparam logic [31:0] SNINF = 32'hFF80_0000, SQN = 32'h7FC0_0000, SSN = 32'h7F80_0001;
  localparam logic [63:0] D1 = 64'h3FF0_0000_0000_0000, D2 = 64'h4000_0000_0000_0000;
  localparam logic [63:0] DN2 = 64'hC000_0000_0000_0000, DQN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] DSN = 64'h7FF0_0000_0000_0001;

  bit finished = 1'b0;

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
    end
  end

  initial begin
    // R11 idle state: reserved format
    go({32'd0, S1}, {32'd0, S2}, 2'd3, 0, 4'b0111, 0, 0, "R11 reserved idle");
    go({32'd0, SSN}, {32'd0, S2}, 2'd3, 0, 4'b1111, 2, 0, "R11 reserved snan");
    // R1 single, upper bits ignored
    go({32'hFFFF_FFFF, S1}, {32'h0, S2}, 2'd0, 0, 4'b0100, 0, 0, "R1 single lt");
    go({32'h7FC0_0000, S2}, {32'h1234_5678, S1}, 2'd0, 0, 4'b0100, 3, 0, "R1 single upper ignored");
    // R2 double
    go(D1, D2, 2'd1, 0, 4'b0100, 1, 0, "R2 double lt");
    go(DN2, D1, 2'd1, 0, 4'b0010, 4, 0, "R2 double eq false");
    go(D2, D2, 2'd1, 0, 4'b0010, 5, 0, "R2 double eq");
    // R3 predicate combos
    go({32'd0, S2}, {32'd0, S1}, 2'd0, 0, 4'b0110, 0, 0, "R3 le with gt");
    go({32'd0, S1}, {32'd0, S1}, 2'd0, 0, 4'b0110, 0, 0, "R3 le with eq");
    go({32'd0, S1}, {32'd0, S1}, 2'd0, 0, 4'b0100, 0, 0, "R3 lt excl eq");
    // R4 NaN unordered
    go({32'd0, SQN}, {32'd0, S1}, 2'd0, 0, 4'b0110, 1, 0, "R4 qnan ordered false");
    go({32'd0, S1}, {32'd0, SQN}, 2'd0, 0, 4'b0001, 1, 0, "R4 qnan unordered true");
    go(DQN, D1, 2'd1, 0, 4'b0001, 2, 0, "R4 double qnan");
    // R5 invalid
    go({32'd0, SSN}, {32'd0, S1}, 2'd0, 0, 4'b0001, 0, 0, "R5 snan invalid");
    go({32'd0, SQN}, {32'd0, S1}, 2'd0, 0, 4'b1001, 0, 0, "R5 qnan signalling pred");
    go(D1, DSN, 2'd1, 0, 4'b0000, 0, 0, "R5 double snan");
    // R6 abs
    go({32'd0, SN1}, {32'd0, S1}, 2'd0, 0, 4'b0010, 2, 0, "R6 no abs neq");
    go({32'd0, SN1}, {32'd0, S1}, 2'd0, 1, 4'b0010, 2, 0, "R6 abs eq");
    go(DN2, D1, 2'd1, 1, 4'b0100, 2, 0, "R6 abs double not lt");
    // R7 zeros, infinities, negatives
    go({32'd0, SNZ}, {32'd0, SZ}, 2'd0, 0, 4'b0010, 3, 0, "R7 zero eq");
    go({32'd0, SNZ}, {32'd0, SZ}, 2'd0, 0, 4'b0100, 3, 0, "R7 zero not lt");
    go({32'd0, SNINF}, {32'd0, SINF}, 2'd0, 0, 4'b0100, 3, 0, "R7 inf order");
    go({32'd0, SN1}, {32'd0, 32'hC000_0000}, 2'd0, 0, 4'b0100, 3, 0, "R7 neg order");
    // R8 paired
    go({S1, S2}, {S2, S1}, 2'd2, 0, 4'b0100, 2, 0, "R8 paired split");
    go({SSN, S1}, {S1, S1}, 2'd2, 0, 4'b0010, 4, 0, "R8 paired status or");
    // R9 index edges
    go({S1, S1}, {S2, S1}, 2'd2, 0, 4'b0110, 6, 0, "R9 paired top pair");
    go({S1, S1}, {S2, S1}, 2'd2, 0, 4'b0110, 7, 0, "R9 paired upper dropped");
    go({32'd0, S1}, {32'd0, S2}, 2'd0, 0, 4'b0100, 7, 0, "R9 single top index");
    // R10 trap
    go({32'd0, SSN}, {32'd0, S1}, 2'd0, 0, 4'b0001, 5, 1, "R10 trap suppresses");
    go({SQN, S1}, {S1, S1}, 2'd2, 0, 4'b1010, 0, 1, "R10 paired trap");
    go({32'd0, SQN}, {32'd0, S1}, 2'd0, 0, 4'b0001, 5, 1, "R10 quiet no trap");
    @(posedge clk);
    @(posedge clk);
    finished = 1'b1;
    summary();
  end

endmodule